// File: doc/BRIEF.md
# General-Purpose I/O Port with Change Interrupts

This block is an eight-pin general-purpose I/O port that a host controls through a small register interface. The interface has a write strobe, a read strobe, a 4-bit register address, 8-bit write data and a combinational read-data bus. Each pin can be an input or an output. Output pins drive the value held in an output latch. Input pins are sampled through a synchroniser. When the host reads the port, each input bit can be inverted.

Any pin can be enabled to raise an interrupt. Each pin uses one of two exclusive comparisons:
- **Change mode:** the pin interrupts when its sampled level differs from its level one cycle earlier.
- **Default mode:** the pin interrupts when its level differs from a per-pin default bit.

Pins that cause an interrupt are recorded in a sticky flag register. When an interrupt fires from idle, the raw sampled port value is copied into a capture register. That copy is held while the interrupt is pending, so the cause can be read later. Reading the capture register or the port register clears the flags.

The interrupt output can be set to one of three styles: push-pull active-low, push-pull active-high, or open-drain. Each pin also has a weak pull-up enable bit, which leaves the block as a control output.

Top module: `gpx_port`

## Requirements
- R1: After a synchronous reset the registers read as follows. Direction (0x00) reads 0xFF, with bit = 1 meaning input. Every other register reads 0x00. No pin output is enabled. The interrupt output is inactive push-pull active-low: `irq_out`=1 and `irq_oe`=1.
- R2: Writable registers read back what was written. They are 0x00 direction, 0x01 polarity, 0x02 interrupt enable, 0x03 default value, 0x04 mode select, 0x05 config, 0x06 pull-up and 0x0A output latch. In config, only bit1 and bit2 are stored; its other bits read 0. `pin_oe` is the inverse of the direction register, and `pin_out` equals the output latch.
- R3: Reading 0x09 returns the pins, after a two-flop synchroniser, XORed bit by bit with the polarity register.
- R4: A pin whose enable bit is 1 and whose mode bit is 0 sets its flag bit when its synchronised level differs from its level one cycle earlier.
- R5: A pin whose enable bit is 1 and whose mode bit is 1 sets its flag bit in every cycle in which its synchronised level differs from the matching default-value bit. A read that clears the flags therefore leaves the flag set while the mismatch remains.
- R6: A pin whose enable bit is 0 never sets its flag, whatever its level does.
- R7: When the flags go from all-zero to non-zero, register 0x08 loads the raw synchronised port value. It is not reloaded while any flag stays set.
- R8: A read strobe at address 0x08 or 0x09 clears the flag register (0x07). After that read, the interrupt is inactive unless a new cause is present.
- R9: The interrupt is active whenever any flag bit is set. Config bit2 set selects open-drain: `irq_oe` is 1 only while active, with `irq_out`=0. Otherwise `irq_oe`=1, and `irq_out` equals the active state when config bit1 is set, or its inverse when it is clear.
- R10: `pull_en` equals the pull-up register (0x06).
- R11: Writes to 0x07, 0x08, 0x09 or an unmapped address change no register. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on or external) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects only) |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| pin_in | input | 8 | Sampled pin levels |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |
| pull_en | output | 8 | Weak pull-up enables |
| irq_out | output | 1 | Interrupt output level |
| irq_oe | output | 1 | Interrupt output enable |

## Verification
The bench looks at three corner cases.
- **Capture while pending.** A second enabled pin changes while an interrupt is already pending. The bench checks that both flags accumulate and that the capture register still holds the first value. A design that reloads capture on every cause would lose the original condition.
- **Clear during a mismatch.** In default mode the port is read while the mismatch persists. The interrupt must stay active, and it must drop only after the pin matches its default and the port is read again. A design that cleared unconditionally would miss a live fault. A design that never cleared would hang the interrupt.
- **Output styles and ignored accesses.** All three interrupt output styles are driven both active and inactive. Writes to the read-only registers and to unmapped addresses must show no effect in any readback.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int unsigned DATA_W      = 8;
    localparam int unsigned ADDR_W      = 4;
    localparam int unsigned SYNC_STAGES = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_DIR  = 4'h0,
        RA_POL  = 4'h1,
        RA_IEN  = 4'h2,
        RA_DEF  = 4'h3,
        RA_MODE = 4'h4,
        RA_CFG  = 4'h5,
        RA_PUE  = 4'h6,
        RA_FLAG = 4'h7,
        RA_CAP  = 4'h8,
        RA_PORT = 4'h9,
        RA_OLAT = 4'hA
    } reg_addr_e;

    typedef struct packed {
        logic open_drain;
        logic active_high;
    } irq_cfg_t;

    typedef struct packed {
        logic oe;
        logic lvl;
    } irq_drive_t;

    function automatic irq_drive_t irq_drive(input logic active, input irq_cfg_t cfg);
        irq_drive_t d;
        if (cfg.open_drain) begin
            d.oe  = active;
            d.lvl = 1'b0;
        end else begin
            d.oe  = 1'b1;
            d.lvl = cfg.active_high ? active : ~active;
        end
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_to_byte(input irq_cfg_t cfg);
        logic [DATA_W-1:0] b;
        b    = '0;
        b[1] = cfg.active_high;
        b[2] = cfg.open_drain;
        return b;
    endfunction

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int unsigned W      = gpx_pkg::DATA_W,
    parameter int unsigned STAGES = gpx_pkg::SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= d_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
    import gpx_pkg::*;
#(
    parameter int unsigned W  = DATA_W,
    parameter int unsigned AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  pol_q,
    output logic [W-1:0]  ien_q,
    output logic [W-1:0]  def_q,
    output logic [W-1:0]  mode_q,
    output logic [W-1:0]  pue_q,
    output logic [W-1:0]  olat_q,
    output irq_cfg_t      cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '1;
            pol_q  <= '0;
            ien_q  <= '0;
            def_q  <= '0;
            mode_q <= '0;
            pue_q  <= '0;
            olat_q <= '0;
            cfg_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                RA_DIR:  dir_q  <= wdata;
                RA_POL:  pol_q  <= wdata;
                RA_IEN:  ien_q  <= wdata;
                RA_DEF:  def_q  <= wdata;
                RA_MODE: mode_q <= wdata;
                RA_PUE:  pue_q  <= wdata;
                RA_OLAT: olat_q <= wdata;
                RA_CFG: begin
                    cfg_q.open_drain  <= wdata[2];
                    cfg_q.active_high <= wdata[1];
                end
                default: ;
            endcase
        end
    end

    assert_reset_dir_R1: assert property (@(posedge clk)
        rst |=> (dir_q == '1 && ien_q == '0 && cfg_q == '0));
endmodule

// File: rtl/gpx_irq.sv
module gpx_irq #(
    parameter int unsigned W = gpx_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins_s,
    input  logic [W-1:0] ien,
    input  logic [W-1:0] defval,
    input  logic [W-1:0] mode,
    input  logic         clear,
    output logic [W-1:0] flags_q,
    output logic [W-1:0] cap_q,
    output logic         active
);
    logic [W-1:0] prev_q;
    logic [W-1:0] cause;
    logic [W-1:0] flags_d;
    logic         idle_eff;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            cause[i] = ien[i] & (mode[i] ? (pins_s[i] ^ defval[i])
                                         : (pins_s[i] ^ prev_q[i]));
        end
    end

    assign idle_eff = clear || (flags_q == '0);
    assign flags_d  = (clear ? '0 : flags_q) | cause;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            flags_q <= '0;
            cap_q   <= '0;
        end else begin
            prev_q  <= pins_s;
            flags_q <= flags_d;
            if (idle_eff && cause != '0) cap_q <= pins_s;
        end
    end

    assign active = (flags_q != '0);

    assert_cap_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (flags_q != '0 && !clear) |=> $stable(cap_q));

    assert_cap_load_R7: assert property (@(posedge clk) disable iff (rst)
        (flags_q == '0 && cause != '0) |=> (cap_q == $past(pins_s)));

    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        !clear |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (clear && cause == '0) |=> (flags_q == '0));
endmodule

// File: rtl/gpx_port.sv
module gpx_port
    import gpx_pkg::*;
#(
    parameter int unsigned W  = DATA_W,
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned NS = SYNC_STAGES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    input  logic [W-1:0]  pin_in,
    output logic [W-1:0]  pin_out,
    output logic [W-1:0]  pin_oe,
    output logic [W-1:0]  pull_en,
    output logic          irq_out,
    output logic          irq_oe
);
    logic [W-1:0] dir_q, pol_q, ien_q, def_q, mode_q, pue_q, olat_q;
    logic [W-1:0] pins_s, flags_q, cap_q;
    irq_cfg_t     cfg_q;
    irq_drive_t   drv;
    logic         clear, active;

    gpx_sync #(.W(W), .STAGES(NS)) i_sync (
        .clk(clk), .rst(rst), .d_in(pin_in), .d_out(pins_s)
    );

    gpx_regs #(.W(W), .AW(AW)) i_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .dir_q(dir_q), .pol_q(pol_q), .ien_q(ien_q), .def_q(def_q),
        .mode_q(mode_q), .pue_q(pue_q), .olat_q(olat_q), .cfg_q(cfg_q)
    );

    assign clear = rd_en && (addr == RA_CAP || addr == RA_PORT);

    gpx_irq #(.W(W)) i_irq (
        .clk(clk), .rst(rst), .pins_s(pins_s), .ien(ien_q), .defval(def_q),
        .mode(mode_q), .clear(clear), .flags_q(flags_q), .cap_q(cap_q),
        .active(active)
    );

    always_comb begin
        case (addr)
            RA_DIR:  rdata = dir_q;
            RA_POL:  rdata = pol_q;
            RA_IEN:  rdata = ien_q;
            RA_DEF:  rdata = def_q;
            RA_MODE: rdata = mode_q;
            RA_CFG:  rdata = cfg_to_byte(cfg_q);
            RA_PUE:  rdata = pue_q;
            RA_FLAG: rdata = flags_q;
            RA_CAP:  rdata = cap_q;
            RA_PORT: rdata = pins_s ^ pol_q;
            RA_OLAT: rdata = olat_q;
            default: rdata = '0;
        endcase
    end

    assign drv     = irq_drive(active, cfg_q);
    assign irq_out = drv.lvl;
    assign irq_oe  = drv.oe;
    assign pin_oe  = ~dir_q;
    assign pin_out = olat_q;
    assign pull_en = pue_q;

    assert_od_low_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.open_drain && irq_oe) |-> (!irq_out && flags_q != '0));
endmodule

// File: tb/test_gpx_port.sv
module test_gpx_port;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en, rd_en;
    logic [3:0] addr;
    logic [7:0] wdata, rdata, pin_in, pin_out, pin_oe, pull_en;
    logic       irq_out, irq_oe;
    int         checks = 0;
    int         fails  = 0;
    bit         done   = 1'b0;

    always #4 clk = ~clk;

    gpx_port i_gpx_port (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pull_en(pull_en), .irq_out(irq_out), .irq_oe(irq_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(4'h0, v); chk("R1 dir", v, 8'hFF);
        for (int a = 1; a <= 10; a++) begin
            rd(a[3:0], v); chk("R1 reg", v, 8'h00);
        end
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 irq_out", {7'd0, irq_out}, 8'h01);
        chk("R1 irq_oe", {7'd0, irq_oe}, 8'h01);
    endtask

    task automatic t_regs;
        logic [7:0] v;
        wr(4'h0, 8'hF0); wr(4'hA, 8'hA5); wr(4'h3, 8'h5A);
        rd(4'h0, v); chk("R2 dir rb", v, 8'hF0);
        rd(4'hA, v); chk("R2 olat rb", v, 8'hA5);
        rd(4'h3, v); chk("R2 def rb", v, 8'h5A);
        chk("R2 pin_oe", pin_oe, 8'h0F);
        chk("R2 pin_out", pin_out, 8'hA5);
        wr(4'h5, 8'hFF); rd(4'h5, v); chk("R2 cfg rb", v, 8'h06);
        wr(4'h5, 8'h00); wr(4'h3, 8'h00);
        wr(4'h6, 8'hC3); rd(4'h6, v); chk("R10 pue rb", v, 8'hC3);
        chk("R10 pull_en", pull_en, 8'hC3);
    endtask

    task automatic t_polarity;
        logic [7:0] v;
        set_pins(8'h3C);
        rd(4'h9, v); chk("R3 port raw", v, 8'h3C);
        wr(4'h1, 8'h0F);
        rd(4'h9, v); chk("R3 port inv", v, 8'h33);
        wr(4'h1, 8'h00);
    endtask

    task automatic t_change_capture;
        logic [7:0] v;
        wr(4'h4, 8'h00); wr(4'h2, 8'h28);
        set_pins(8'h34);
        chk("R4 irq low", {7'd0, irq_out}, 8'h00);
        rd(4'h7, v); chk("R4 flags", v, 8'h08);
        set_pins(8'h14);
        rd(4'h7, v); chk("R7 flags accum", v, 8'h28);
        rd(4'h8, v); chk("R7 cap held", v, 8'h34);
        chk("R8 irq cleared", {7'd0, irq_out}, 8'h01);
        rd(4'h7, v); chk("R8 flags cleared", v, 8'h00);
    endtask

    task automatic t_default_mode;
        logic [7:0] v;
        wr(4'h2, 8'h01); wr(4'h4, 8'h01); wr(4'h3, 8'h00);
        set_pins(8'h15);
        rd(4'h7, v); chk("R5 flag", v, 8'h01);
        rd(4'h9, v);
        chk("R5 persists", {7'd0, irq_out}, 8'h00);
        set_pins(8'h14);
        rd(4'h9, v);
        chk("R8 irq released", {7'd0, irq_out}, 8'h01);
    endtask

    task automatic t_disabled;
        logic [7:0] v;
        wr(4'h2, 8'h00); wr(4'h4, 8'h00);
        set_pins(8'h94);
        set_pins(8'h14);
        rd(4'h7, v); chk("R6 no flag", v, 8'h00);
        chk("R6 irq idle", {7'd0, irq_out}, 8'h01);
    endtask

    task automatic t_irq_styles;
        logic [7:0] v;
        wr(4'h2, 8'h01); wr(4'h4, 8'h01);
        set_pins(8'h15);
        wr(4'h5, 8'h02);
        chk("R9 ah out", {7'd0, irq_out}, 8'h01);
        chk("R9 ah oe", {7'd0, irq_oe}, 8'h01);
        wr(4'h5, 8'h04);
        chk("R9 od active", {6'd0, irq_oe, irq_out}, 8'h02);
        set_pins(8'h14);
        rd(4'h9, v);
        chk("R9 od idle", {6'd0, irq_oe, irq_out}, 8'h00);
        wr(4'h5, 8'h02);
        chk("R9 ah idle", {6'd0, irq_oe, irq_out}, 8'h02);
        wr(4'h5, 8'h00); wr(4'h2, 8'h00); wr(4'h4, 8'h00);
    endtask

    task automatic t_readonly;
        logic [7:0] v, c0;
        rd(4'h8, c0);
        wr(4'h7, 8'hFF); rd(4'h7, v); chk("R11 flag wr", v, 8'h00);
        wr(4'h8, 8'hAA); rd(4'h8, v); chk("R11 cap wr", v, c0);
        wr(4'h9, 8'hFF); rd(4'hA, v); chk("R11 port wr", v, 8'hA5);
        wr(4'hF, 8'hFF); rd(4'hF, v); chk("R11 unmapped", v, 8'h00);
        rd(4'h0, v); chk("R11 dir intact", v, 8'hF0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; pin_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_polarity();
        t_change_capture();
        t_default_mode();
        t_disabled();
        t_irq_styles();
        t_readonly();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule